// File: doc/BRIEF.md
# Conversion Start Arbiter with Auto-Trigger

This block decides the clock cycle in which a converter sequencer begins a new conversion. A conversion can start in three ways. Software can write the start bit. A rising edge can arrive on one of several external trigger lines while auto-triggering is on. Or, when the selector picks the completion flag, the arbiter restarts the converter after every completion on its own, which is free-running operation. Each start is a single-cycle `start_req` pulse to the sequencer. A start that comes from a trigger, rather than from software, also raises `prst_req` in the same cycle so that the clock prescaler realigns to the trigger.

Every external trigger line passes through its own synchroniser. Edges are detected per line in the system clock domain before the selector picks one, so changing the selector never creates a false edge. A small state machine holds the launch decision. Its states are:

- `ST_IDLE`: waiting for a start.
- `ST_SW_GO`: a software start is being issued.
- `ST_AUTO_GO`: a trigger or free-running start is being issued.
- `ST_CONV`: a conversion is in progress.

Its transitions are:

- `ST_IDLE` to `ST_SW_GO` on a start write.
- `ST_IDLE` to `ST_AUTO_GO` on a qualified edge.
- `ST_SW_GO` or `ST_AUTO_GO` to `ST_CONV` unconditionally.
- `ST_CONV` to `ST_AUTO_GO` on completion in free-running mode.
- `ST_CONV` to `ST_IDLE` on any other completion.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `start_req` and `prst_req` are both low.
- R2: A `sw_start` sampled high while the arbiter is idle and `busy` is low gives a `start_req` pulse in the next cycle with `prst_req` low, whether `auto_en` is set or not.
- R3: Selector code k (1 to NUM_SRC-1) picks `trig_src[k-1]`. With `auto_en` high, `done_flag` low and the arbiter idle, a line sampled high at clock edge n after being low at edge n-1 gives `start_req` and `prst_req` together after edge n+2. That is three cycles of synchronisation.
- R4: Rising edges on the selected line are dropped while `busy` is high or while a conversion is in progress, meaning from the start pulse until `conv_done`.
- R5: A selected line that is still high when a conversion completes does not start a new conversion; a fresh rising edge is needed.
- R6: For selector codes other than 0, an edge that arrives while `done_flag` is high is ignored.
- R7: With `auto_en` high and selector code 0, which picks the completion flag, every `conv_done` gives `start_req` with `prst_req` in the next cycle, whatever the value of `done_flag`.
- R8: With selector code 0, no activity on the trigger lines or on `done_flag` starts a conversion; the first one needs `sw_start`.
- R9: With `auto_en` low, trigger-line edges start nothing, and `conv_done` never relaunches.
- R10: `start_req` lasts one cycle. A `sw_start` held high, or repeated before `conv_done`, produces no second start.
- R11: Edges on trigger lines that the selector does not pick have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_src | input | NUM_SRC-1 | Asynchronous external trigger lines |
| trig_sel | input | $clog2(NUM_SRC) | Trigger selector; code 0 selects the completion flag (free-running) |
| auto_en | input | 1 | Auto-trigger enable |
| sw_start | input | 1 | Software start-bit write strobe |
| busy | input | 1 | Sequencer reports a conversion running |
| conv_done | input | 1 | One-cycle pulse when a conversion completes |
| done_flag | input | 1 | Completion flag level, cleared by software |
| start_req | output | 1 | One-cycle conversion start request |
| prst_req | output | 1 | Prescaler reset request, issued with trigger-driven starts |

## Verification
The bench builds the arbiter with eight selector codes and two synchroniser stages. With those values every selector code is reachable: the flag code 0, the lines that are selected, and lines that are left unselected. The three-cycle latency from a line to `start_req` is then fixed and exact, and the bench checks it to the cycle. The bench sequences drive free-running relaunches with the flag left set. They also place a second edge inside a running conversion, hold a line high across a completion, and hold the start strobe for several cycles.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    // Selector code that picks the completion flag (free-running mode)
    localparam int FLAG_SEL = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SW_GO   = 2'd1,
        ST_AUTO_GO = 2'd2,
        ST_CONV    = 2'd3
    } trig_state_e;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_out
);

    logic [WIDTH-1:0] prev_q;

    // One detector per line, so a selector change cannot fake an edge
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_det
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q[i] <= 1'b0;
                end else begin
                    prev_q[i] <= level_in[i];
                end
            end
            assign rise_out[i] = level_in[i] & ~prev_q[i];
        end
    endgenerate

    // R5: a rise lasts exactly one cycle while the level stays high
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chk
            p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (rise_out[i] && level_in[i]) |=> !rise_out[i]);
        end
    endgenerate

endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SEL_W  = $clog2(NUM_SRC),
    localparam int EXT_N  = NUM_SRC - 1
) (
    input  logic [EXT_N-1:0] rise_vec,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_rise,
    output logic             free_sel
);

    assign free_sel = (sel == SEL_W'(FLAG_SEL));

    // Code k (k >= 1) picks external line k-1; unused codes pick nothing
    always_comb begin
        sel_rise = 1'b0;
        for (int i = 0; i < EXT_N; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                sel_rise = rise_vec[i];
            end
        end
    end

    // R8: the flag code never forwards an external edge
    always_comb begin
        if (free_sel) begin
            a_flag_code_quiet_r8: assert (!sel_rise);
        end
    end

endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic auto_en,
    input  logic free_sel,
    input  logic sel_rise,
    input  logic done_flag,
    input  logic busy,
    input  logic conv_done,
    output logic start_req,
    output logic prst_req
);

    trig_state_e state_q, state_d;
    logic        edge_ok;

    // A line edge qualifies only for ordinary sources with the flag clear
    assign edge_ok = auto_en && !free_sel && sel_rise && !done_flag;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy) begin
                    state_d = ST_IDLE;
                end else if (sw_start) begin
                    state_d = ST_SW_GO;
                end else if (edge_ok) begin
                    state_d = ST_AUTO_GO;
                end
            end
            ST_SW_GO:   state_d = ST_CONV;
            ST_AUTO_GO: state_d = ST_CONV;
            ST_CONV: begin
                if (conv_done) begin
                    state_d = (auto_en && free_sel) ? ST_AUTO_GO : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start_req = 1'b0;
        prst_req  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SW_GO:   start_req = 1'b1;
            ST_AUTO_GO: begin
                start_req = 1'b1;
                prst_req  = 1'b1;
            end
            ST_CONV: ;
            default: ;
        endcase
    end

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);

    p_prst_with_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prst_req |-> start_req);

    p_sw_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !busy && sw_start) |=> (start_req && !prst_req));

    p_conv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !conv_done) |=> !start_req);

    p_busy_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && busy) |=> !start_req);

    p_flag_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sw_start && done_flag) |=> !start_req);

    p_free_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && conv_done && auto_en && free_sel) |=> (start_req && prst_req));

    p_no_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && conv_done && !auto_en) |=> !start_req);

    p_manual_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !auto_en && !sw_start) |=> !start_req);

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-2:0] trig_src,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic               auto_en,
    input  logic               sw_start,
    input  logic               busy,
    input  logic               conv_done,
    input  logic               done_flag,
    output logic               start_req,
    output logic               prst_req
);

    localparam int EXT_N = NUM_SRC - 1;

    logic [EXT_N-1:0] src_sync;
    logic [EXT_N-1:0] src_rise;
    logic             sel_rise;
    logic             free_sel;

    adc_trig_sync #(
        .WIDTH  (EXT_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_src),
        .sync_out (src_sync)
    );

    adc_trig_edge #(
        .WIDTH (EXT_N)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (src_sync),
        .rise_out (src_rise)
    );

    adc_trig_select #(
        .NUM_SRC (NUM_SRC)
    ) u_select (
        .rise_vec (src_rise),
        .sel      (trig_sel),
        .sel_rise (sel_rise),
        .free_sel (free_sel)
    );

    adc_trig_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_start  (sw_start),
        .auto_en   (auto_en),
        .free_sel  (free_sel),
        .sel_rise  (sel_rise),
        .done_flag (done_flag),
        .busy      (busy),
        .conv_done (conv_done),
        .start_req (start_req),
        .prst_req  (prst_req)
    );

endmodule

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;

    localparam int NUM_SRC = 8;
    localparam int SEL_W   = $clog2(NUM_SRC);

    typedef struct {
        int    cyc;
        bit    prst;
        string tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-2:0] trig_src = '0;
    logic [SEL_W-1:0]   trig_sel = '0;
    logic               auto_en = 1'b0;
    logic               sw_start = 1'b0;
    logic               busy = 1'b0;
    logic               conv_done = 1'b0;
    logic               done_flag = 1'b0;
    logic               start_req;
    logic               prst_req;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   seen = 0;
    bit   fin = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    adc_trig_ctrl #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (2)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_src  (trig_src),
        .trig_sel  (trig_sel),
        .auto_en   (auto_en),
        .sw_start  (sw_start),
        .busy      (busy),
        .conv_done (conv_done),
        .done_flag (done_flag),
        .start_req (start_req),
        .prst_req  (prst_req)
    );

    // Monitor: pops expected starts and compares cycle and prescaler flag
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (prst_req && !start_req) begin
                fails++;
                $display("FAIL R3 prst_req without start at cyc=%0d actual=1 expected=0", cyc);
            end
            if (start_req) begin
                seen++;
                if (q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R10 unexpected start at cyc=%0d actual=start expected=none", cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (e.cyc != cyc || e.prst != prst_req) begin
                        fails++;
                        $display("FAIL %s start cyc/prst actual=%0d/%0d expected=%0d/%0d",
                                 e.tag, cyc, prst_req, e.cyc, e.prst);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_go(input string tag);
        @(negedge clk);
        sw_start = 1'b1;
        q.push_back('{cyc + 1, 1'b0, tag});
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic src_rise(input int idx, input bit expect_go, input string tag);
        @(negedge clk);
        trig_src[idx] = 1'b1;
        if (expect_go) q.push_back('{cyc + 3, 1'b1, tag});
    endtask

    task automatic src_low(input int idx);
        @(negedge clk);
        trig_src[idx] = 1'b0;
    endtask

    task automatic conv(input int len, input bit relaunch, input bit keep_flag);
        @(negedge clk);
        busy = 1'b1;
        tick(len);
        conv_done = 1'b1;
        busy = 1'b0;
        done_flag = 1'b1;
        if (relaunch) q.push_back('{cyc + 1, 1'b1, "R7"});
        @(negedge clk);
        conv_done = 1'b0;
        if (!keep_flag) done_flag = 1'b0;
    endtask

    task automatic check_none(input int n, input string tag);
        int s0;
        s0 = seen;
        tick(n);
        checks++;
        if (seen != s0) begin
            fails++;
            $display("FAIL %s starts seen actual=%0d expected=%0d", tag, seen - s0, 0);
        end
    endtask

    task automatic finish_run();
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s missing start actual=none expected=cyc %0d", e.tag, e.cyc);
        end
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            fin = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        checks++;
        if (start_req !== 1'b0 || prst_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 outputs in reset actual=%b%b expected=00", start_req, prst_req);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (start_req !== 1'b0 || prst_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 outputs after reset actual=%b%b expected=00", start_req, prst_req);
        end

        // R2: software start with auto-trigger off
        sw_go("R2");
        conv(5, 1'b0, 1'b0);

        // R9: line edge with auto-trigger off
        trig_sel = SEL_W'(2);
        src_rise(1, 1'b0, "R9");
        check_none(8, "R9");
        src_low(1);
        tick(3);

        // R3: selected line edge, exact latency; R5: held high across completion
        auto_en = 1'b1;
        src_rise(1, 1'b1, "R3");
        tick(3);
        conv(4, 1'b0, 1'b1);
        check_none(8, "R5");
        src_low(1);
        tick(3);

        // R6: flag still set, new edge ignored
        src_rise(1, 1'b0, "R6");
        check_none(8, "R6");
        src_low(1);
        done_flag = 1'b0;
        tick(3);

        // R4: busy reported while idle blocks an edge
        busy = 1'b1;
        src_rise(1, 1'b0, "R4");
        check_none(8, "R4");
        src_low(1);
        busy = 1'b0;
        tick(3);

        // R4: edge inside a running conversion is dropped
        src_rise(1, 1'b1, "R4");
        tick(3);
        busy = 1'b1;
        trig_src[1] = 1'b0;
        tick(2);
        trig_src[1] = 1'b1;
        tick(6);
        conv(2, 1'b0, 1'b0);
        check_none(8, "R4");
        src_low(1);
        tick(3);

        // R11: unselected line
        src_rise(4, 1'b0, "R11");
        check_none(8, "R11");
        src_low(4);
        tick(3);

        // R2: software start while auto-trigger is on
        trig_sel = SEL_W'(3);
        sw_go("R2");
        conv(3, 1'b0, 1'b0);

        // R8: flag code selected, nothing but software starts it
        trig_sel = SEL_W'(0);
        @(negedge clk);
        trig_src = '1;
        done_flag = 1'b1;
        tick(3);
        trig_src = '0;
        done_flag = 1'b0;
        check_none(10, "R8");
        sw_go("R8");

        // R7: free-running relaunch with the flag left set
        conv(4, 1'b1, 1'b1);
        conv(3, 1'b1, 1'b1);
        conv(5, 1'b1, 1'b1);
        auto_en = 1'b0;
        conv(4, 1'b0, 1'b0);
        check_none(8, "R9");

        // R10: start strobe held for several cycles
        @(negedge clk);
        sw_start = 1'b1;
        q.push_back('{cyc + 1, 1'b0, "R10"});
        tick(4);
        sw_start = 1'b0;
        conv(3, 1'b0, 1'b0);
        check_none(6, "R10");

        tick(5);
        finish_run();
    end

endmodule